// File: doc/BRIEF.md
# MAC Address Table Command Engine

This block holds the address table of a small learning switch and manages it through three host-visible 32-bit registers. The host loads a MAC address and an entry word (destination port mask plus a 4-bit status), then writes a command word with a 3-bit function code and the busy bit set. The engine walks its internal entry array one entry per clock, runs the command, puts any result back into the same registers and clears busy. The host polls busy to learn when the command has finished.

The commands are: insert or overwrite an entry, remove an entry, find an address, step through the valid entries one by one, and three kinds of flush (everything, every non-static entry, or the dynamic unicast entries of one port). The status word tells an empty slot (0), a dynamic entry at aging level 1 to 7, and a static entry (15). A periodic age tick, when aging is enabled, moves every dynamic entry one level closer to empty. A separate lookup port lets the forwarding datapath ask for the destination mask of an address. Lookups share the same search engine as the host commands.

Top module: `mac_table_engine`

## Requirements
- R1: After reset the busy bit (command register bit 3) reads 1 while the engine clears every table slot, one slot per clock. It then reads 0, the command register reads zero and every address is absent.
- R2: The command register holds the function code in bits 2:0 and busy in bit 3. Writing it with bit 3 set starts the command, and busy clears when the command completes. Code 0 completes without touching the table or the entry register. Any register write while busy is 1 is ignored.
- R3: An address is split across two registers. The address register carries bytes 0..3, with byte 0 in bits 31:24 down to byte 3 in bits 7:0. The command register carries byte 4 in bits 31:24 and byte 5 in bits 23:16. The entry register carries the status in bits 19:16 and the port mask in bits PW-1:0.
- R4: Code 2 (load) writes address, mask and status into a free slot. If the address is already present, it overwrites that entry in place. Code 7 (find) returns the stored status and mask in the entry register. For an absent address it returns an all-zero entry register.
- R5: Code 3 (purge) empties the entry that holds the given address.
- R6: Code 6 (get-next) with a zero address and zero status returns the first valid entry from slot 0, with its address in the address fields. With any other cursor it returns the next valid slot after the entry holding the cursor address. When no further entry exists it returns an all-zero entry register.
- R7: A load of an absent address into a table with no empty slot leaves the table unchanged and sets the full flag in command register bit 12. The next write to the command register clears the flag.
- R8: Code 1 empties every slot. Code 4 empties every dynamic slot (status 1..7) and keeps static ones (status 15).
- R9: Code 5 takes a port number in command register bits 11:8. It empties each dynamic entry whose mask has that port's bit set and whose address is unicast (bit 0 of byte 0 clear). Static entries, multicast entries and entries of other ports stay.
- R10: An age tick taken while age enable is high decrements every dynamic status by one, and a status of 1 becomes empty. Static entries are never aged. A tick with age enable low has no effect.
- R11: A lookup request returns, on a one-cycle done pulse, hit=1 and the stored mask for a present address, or hit=0 and a zero mask for an absent one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 2 | Register select: 0 command, 1 address, 2 entry |
| host_wdata | input | 32 | Host write data |
| reg_cmd | output | 32 | Command register: address bytes 4/5, full flag, port number, busy, function |
| reg_addr | output | 32 | Address register: address bytes 0..3 |
| reg_entry | output | 32 | Entry register: status and destination mask |
| age_en | input | 1 | Aging enable |
| age_tick | input | 1 | Periodic aging pulse |
| lk_req | input | 1 | Datapath lookup request |
| lk_mac | input | 48 | Address to look up |
| lk_done | output | 1 | One-cycle pulse: lookup result valid |
| lk_hit | output | 1 | Lookup found the address |
| lk_mask | output | PW | Destination mask of the found entry |

## Verification
A corrupted slot shows up at the ports at the next command or lookup that scans it. A find or lookup returns the wrong status or mask, and a get-next walk skips, repeats or invents entries. A wrong free-slot choice appears as an early or missing full flag once the table is filled to its last slot. A stuck or misrouted busy bit shows within one scan time, which is depth plus two cycles: completion events then arrive that no command explains, or expected ones never arrive.

// File: rtl/mte_pkg.sv
package mte_pkg;

  typedef enum logic [2:0] {
    F_NOP        = 3'd0,
    F_FLUSH_ALL  = 3'd1,
    F_LOAD       = 3'd2,
    F_PURGE      = 3'd3,
    F_FLUSH_DYN  = 3'd4,
    F_FLUSH_PORT = 3'd5,
    F_NEXT       = 3'd6,
    F_FIND       = 3'd7
  } func_e;

  typedef enum logic [1:0] {S_INIT, S_IDLE, S_SCAN} state_e;
  typedef enum logic [1:0] {OP_CMD, OP_AGE, OP_LOOK} op_e;

  localparam logic [3:0]  ST_EMPTY  = 4'h0;
  localparam logic [3:0]  ST_STATIC = 4'hF;
  localparam logic [1:0]  SEL_CMD   = 2'd0;
  localparam logic [1:0]  SEL_ADDR  = 2'd1;
  localparam logic [1:0]  SEL_ENTRY = 2'd2;
  localparam int          BUSY_BIT  = 3;
  localparam int          FULL_BIT  = 12;
  localparam logic [31:0] CMD_WMASK = 32'hFFFF_0F0F;

endpackage

// File: rtl/mte_ram.sv
module mte_ram #(
  parameter int DEPTH = 1024,
  parameter int W     = 58,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // simple dual-port: one synchronous write, one registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/mte_eval.sv
module mte_eval
  import mte_pkg::*;
#(
  parameter int PW = 6
) (
  input  logic [47:0]   e_mac,
  input  logic [PW-1:0] e_mask,
  input  logic [3:0]    e_stat,
  input  logic [47:0]   key,
  input  logic [3:0]    port,
  output logic          valid,
  output logic          dyn,
  output logic          hit,
  output logic          on_port,
  output logic          unicast
);

  always_comb begin
    valid   = (e_stat != ST_EMPTY);
    dyn     = valid && (e_stat != ST_STATIC);
    hit     = valid && (e_mac == key);
    unicast = ~e_mac[40];
    on_port = 1'b0;
    for (int i = 0; i < PW; i++) begin
      if (port == 4'(i)) on_port = e_mask[i];
    end
  end

endmodule

// File: rtl/mac_table_engine.sv
module mac_table_engine
  import mte_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int PW    = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [1:0]    host_sel,
  input  logic [31:0]   host_wdata,
  output logic [31:0]   reg_cmd,
  output logic [31:0]   reg_addr,
  output logic [31:0]   reg_entry,
  input  logic          age_en,
  input  logic          age_tick,
  input  logic          lk_req,
  input  logic [47:0]   lk_mac,
  output logic          lk_done,
  output logic          lk_hit,
  output logic [PW-1:0] lk_mask
);

  localparam int          IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int          EW   = 48 + PW + 4;
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  state_e          state;
  op_e             op;
  func_e           func_q;
  logic [31:0]     cmd_q, addr_q, entry_q;
  logic [47:0]     key_q, lk_key, host_key;
  logic [IW-1:0]   idx, q_idx, free_idx, wa;
  logic            issued_all, q_vld, armed, free_found;
  logic            age_pend, lk_pend;
  logic [EW-1:0]   rd_q, wd;
  logic            we, fin, q_last;
  logic [47:0]     e_mac;
  logic [PW-1:0]   e_mask;
  logic [3:0]      e_stat;
  logic            valid, dyn, hit, on_port, unicast;

  assign reg_cmd   = cmd_q;
  assign reg_addr  = addr_q;
  assign reg_entry = entry_q;
  assign host_key  = {addr_q, cmd_q[31:16]};

  assign e_mac  = rd_q[EW-1 -: 48];
  assign e_mask = rd_q[4 +: PW];
  assign e_stat = rd_q[3:0];
  assign q_last = q_vld && (q_idx == LAST);

  function automatic logic [31:0] pack_entry(input logic [3:0] s, input logic [PW-1:0] m);
    logic [31:0] r;
    r = '0;
    r[19:16] = s;
    r[PW-1:0] = m;
    return r;
  endfunction

  mte_ram #(.DEPTH(DEPTH), .W(EW), .AW(IW)) u_ram (
    .clk   (clk),
    .we    (we),
    .waddr (wa),
    .wdata (wd),
    .raddr (idx),
    .rdata (rd_q)
  );

  mte_eval #(.PW(PW)) u_eval (
    .e_mac   (e_mac),
    .e_mask  (e_mask),
    .e_stat  (e_stat),
    .key     (key_q),
    .port    (cmd_q[11:8]),
    .valid   (valid),
    .dyn     (dyn),
    .hit     (hit),
    .on_port (on_port),
    .unicast (unicast)
  );

  // per-entry decision: table write-back and end of scan
  always_comb begin
    we  = 1'b0;
    wa  = q_idx;
    wd  = rd_q;
    fin = 1'b0;
    if (state == S_INIT) begin
      we = 1'b1;
      wa = idx;
      wd = '0;
    end else if (state == S_SCAN && q_vld) begin
      fin = q_last;
      case (op)
        OP_AGE: begin
          we = dyn;
          wd = {e_mac, e_mask, e_stat - 4'd1};
        end
        OP_LOOK: if (hit) fin = 1'b1;
        default: begin
          case (func_q)
            F_FLUSH_ALL:  begin we = valid; wd = '0; end
            F_FLUSH_DYN:  begin we = dyn;   wd = '0; end
            F_FLUSH_PORT: begin we = dyn && unicast && on_port; wd = '0; end
            F_PURGE: if (hit) begin
              we = 1'b1; wd = '0; fin = 1'b1;
            end
            F_LOAD: begin
              wd = {key_q, entry_q[PW-1:0], entry_q[19:16]};
              if (hit) begin
                we = 1'b1; fin = 1'b1;
              end else if (q_last && (free_found || !valid)) begin
                we = 1'b1;
                wa = free_found ? free_idx : q_idx;
              end
            end
            F_NEXT: if (armed && valid) fin = 1'b1;
            F_FIND: if (hit) fin = 1'b1;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_INIT;
      op         <= OP_CMD;
      func_q     <= F_NOP;
      cmd_q      <= 32'h0000_0008;
      addr_q     <= '0;
      entry_q    <= '0;
      key_q      <= '0;
      lk_key     <= '0;
      idx        <= '0;
      q_idx      <= '0;
      free_idx   <= '0;
      issued_all <= 1'b0;
      q_vld      <= 1'b0;
      armed      <= 1'b0;
      free_found <= 1'b0;
      age_pend   <= 1'b0;
      lk_pend    <= 1'b0;
      lk_done    <= 1'b0;
      lk_hit     <= 1'b0;
      lk_mask    <= '0;
    end else begin
      lk_done <= 1'b0;

      if (host_we && !cmd_q[BUSY_BIT]) begin
        case (host_sel)
          SEL_CMD:   cmd_q   <= host_wdata & CMD_WMASK;
          SEL_ADDR:  addr_q  <= host_wdata;
          SEL_ENTRY: entry_q <= pack_entry(host_wdata[19:16], host_wdata[PW-1:0]);
          default: ;
        endcase
      end

      if (age_tick && age_en) age_pend <= 1'b1;
      if (lk_req && !lk_pend) begin
        lk_pend <= 1'b1;
        lk_key  <= lk_mac;
      end

      case (state)
        S_INIT: begin
          idx <= idx + 1'b1;
          if (idx == LAST) begin
            state           <= S_IDLE;
            idx             <= '0;
            cmd_q[BUSY_BIT] <= 1'b0;
          end
        end

        S_IDLE: begin
          idx        <= '0;
          issued_all <= 1'b0;
          q_vld      <= 1'b0;
          free_found <= 1'b0;
          if (cmd_q[BUSY_BIT]) begin
            op     <= OP_CMD;
            func_q <= func_e'(cmd_q[2:0]);
            key_q  <= host_key;
            armed  <= (host_key == 48'd0) && (entry_q[19:16] == ST_EMPTY);
            if (cmd_q[2:0] == F_NOP) cmd_q[BUSY_BIT] <= 1'b0;
            else                     state <= S_SCAN;
          end else if (age_pend) begin
            op       <= OP_AGE;
            age_pend <= 1'b0;
            state    <= S_SCAN;
          end else if (lk_pend) begin
            op      <= OP_LOOK;
            key_q   <= lk_key;
            lk_pend <= 1'b0;
            state   <= S_SCAN;
          end
        end

        default: begin // S_SCAN
          if (!issued_all) begin
            q_vld <= 1'b1;
            q_idx <= idx;
            idx   <= idx + 1'b1;
            if (idx == LAST) issued_all <= 1'b1;
          end else begin
            q_vld <= 1'b0;
          end

          if (q_vld && op == OP_CMD && func_q == F_LOAD && !free_found && !valid) begin
            free_found <= 1'b1;
            free_idx   <= q_idx;
          end
          if (q_vld && op == OP_CMD && func_q == F_NEXT && !armed && hit)
            armed <= 1'b1;

          if (fin) begin
            state <= S_IDLE;
            q_vld <= 1'b0;
            case (op)
              OP_LOOK: begin
                lk_done <= 1'b1;
                lk_hit  <= hit;
                lk_mask <= hit ? e_mask : '0;
              end
              OP_CMD: begin
                cmd_q[BUSY_BIT] <= 1'b0;
                case (func_q)
                  F_LOAD: if (!hit && !(free_found || !valid)) cmd_q[FULL_BIT] <= 1'b1;
                  F_NEXT: begin
                    if (armed && valid) begin
                      addr_q        <= e_mac[47:16];
                      cmd_q[31:16]  <= e_mac[15:0];
                      entry_q       <= pack_entry(e_stat, e_mask);
                    end else begin
                      entry_q <= '0;
                    end
                  end
                  F_FIND: entry_q <= hit ? pack_entry(e_stat, e_mask) : '0;
                  default: ;
                endcase
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/mte_checker.sv
module mte_checker #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          full,
  input logic [2:0]    func,
  input logic [31:0]   entry,
  input logic          lk_done,
  input logic          lk_hit,
  input logic [PW-1:0] lk_mask
);

  // R2: host writes while busy cannot change the running function
  a_r2_func_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> func == $past(func));

  // R7: the full flag appears only as a load completes
  a_r7_full_on_load: assert property (@(posedge clk) disable iff (rst)
    $rose(full) |-> (!busy && func == 3'd2));

  // R4: a find that reports empty status leaves an all-zero entry word
  a_r4_find_miss_zero: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && func == 3'd7 && entry[19:16] == 4'd0) |-> entry == 32'd0);

  // R6: get-next end of table reports an all-zero entry word
  a_r6_next_end_zero: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && func == 3'd6 && entry[19:16] == 4'd0) |-> entry == 32'd0);

  // R11: done is a single-cycle pulse
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
    lk_done |=> !lk_done);

  // R11: a lookup miss carries no mask
  a_r11_miss_mask: assert property (@(posedge clk) disable iff (rst)
    (lk_done && !lk_hit) |-> lk_mask == '0);

endmodule

bind mac_table_engine mte_checker #(.PW(PW)) u_mte_checker (
  .clk     (clk),
  .rst     (rst),
  .busy    (reg_cmd[3]),
  .full    (reg_cmd[12]),
  .func    (reg_cmd[2:0]),
  .entry   (reg_entry),
  .lk_done (lk_done),
  .lk_hit  (lk_hit),
  .lk_mask (lk_mask)
);

// File: tb/mac_table_engine_bench.sv
`timescale 1ns/1ps
module mac_table_engine_bench;

  localparam int DEPTH = 8;
  localparam int PW    = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          host_we = 1'b0;
  logic [1:0]    host_sel = 2'd0;
  logic [31:0]   host_wdata = '0;
  logic [31:0]   reg_cmd, reg_addr, reg_entry;
  logic          age_en = 1'b0, age_tick = 1'b0;
  logic          lk_req = 1'b0;
  logic [47:0]   lk_mac = '0;
  logic          lk_done, lk_hit;
  logic [PW-1:0] lk_mask;

  always #2 clk = ~clk;

  mac_table_engine #(.DEPTH(DEPTH), .PW(PW)) u_mac_table_engine (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .reg_cmd(reg_cmd), .reg_addr(reg_addr),
    .reg_entry(reg_entry), .age_en(age_en), .age_tick(age_tick),
    .lk_req(lk_req), .lk_mac(lk_mac), .lk_done(lk_done), .lk_hit(lk_hit),
    .lk_mask(lk_mask)
  );

  typedef struct {
    string       tag;
    logic [31:0] ent;
    logic [47:0] mac;
    bit          full;
  } cmd_exp_t;

  typedef struct {
    string         tag;
    bit            hit;
    logic [PW-1:0] mask;
  } lk_exp_t;

  cmd_exp_t cq[$];
  lk_exp_t  lq[$];
  int n_chk = 0, n_fail = 0;
  bit init_seen = 0, busy_prev = 1;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ent(logic [3:0] s, logic [PW-1:0] m);
    logic [31:0] r;
    r = '0;
    r[19:16] = s;
    r[PW-1:0] = m;
    return r;
  endfunction

  // monitor: pop one expectation per command completion / lookup result
  always @(negedge clk) begin
    if (!rst) begin
      if (busy_prev && !reg_cmd[3]) begin
        if (!init_seen) init_seen = 1;
        else if (cq.size() == 0) check(0, "R2 unexpected completion", 64'(reg_cmd), 64'd0);
        else begin
          cmd_exp_t e;
          e = cq.pop_front();
          check(reg_entry == e.ent, {e.tag, " entry"}, 64'(reg_entry), 64'(e.ent));
          check({reg_addr, reg_cmd[31:16]} == e.mac, {e.tag, " mac"},
                64'({reg_addr, reg_cmd[31:16]}), 64'(e.mac));
          check(reg_cmd[12] == e.full, {e.tag, " full"}, 64'(reg_cmd[12]), 64'(e.full));
        end
      end
      busy_prev = reg_cmd[3];
      if (lk_done) begin
        if (lq.size() == 0) check(0, "R11 unexpected done", 64'(lk_hit), 64'd0);
        else begin
          lk_exp_t l;
          l = lq.pop_front();
          check(lk_hit == l.hit, {l.tag, " hit"}, 64'(lk_hit), 64'(l.hit));
          check(lk_mask == l.mask, {l.tag, " mask"}, 64'(lk_mask), 64'(l.mask));
        end
      end
    end
  end

  task automatic wr(logic [1:0] sel, logic [31:0] data);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = data;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (reg_cmd[3]) @(negedge clk);
  endtask

  // driver: push expectation, then start the command
  task automatic issue(string tag, logic [2:0] f, logic [47:0] mac, logic [31:0] ew,
                       logic [3:0] port, logic [31:0] exp_ent, logic [47:0] exp_mac,
                       bit exp_full);
    cmd_exp_t e;
    wr(2'd1, mac[47:16]);
    wr(2'd2, ew);
    e.tag = tag; e.ent = exp_ent; e.mac = exp_mac; e.full = exp_full;
    cq.push_back(e);
    wr(2'd0, {mac[15:0], 4'h0, port, 4'h0, 1'b1, f});
  endtask

  task automatic op(string tag, logic [2:0] f, logic [47:0] mac, logic [31:0] ew,
                    logic [31:0] exp_ent);
    issue(tag, f, mac, ew, 4'd0, exp_ent, mac, 1'b0);
    wait_idle();
  endtask

  task automatic find(string tag, logic [47:0] mac, logic [31:0] exp_ent);
    op(tag, 3'd7, mac, 32'd0, exp_ent);
  endtask

  task automatic lookup(string tag, logic [47:0] mac, bit hit, logic [PW-1:0] mask);
    lk_exp_t l;
    l.tag = tag; l.hit = hit; l.mask = mask;
    lq.push_back(l);
    @(negedge clk);
    lk_req = 1'b1; lk_mac = mac;
    @(negedge clk);
    lk_req = 1'b0;
    repeat (DEPTH + 6) @(negedge clk);
  endtask

  task automatic age_pulse(bit en);
    @(negedge clk);
    age_en = en; age_tick = 1'b1;
    @(negedge clk);
    age_tick = 1'b0;
    repeat (DEPTH + 6) @(negedge clk);
    age_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  localparam logic [47:0] MA = 48'h02_11_22_33_44_55;
  localparam logic [47:0] MB = 48'h02_AA_BB_CC_DD_01;
  localparam logic [47:0] MC = 48'h01_00_5E_00_00_01;
  localparam logic [47:0] MS = 48'h02_00_00_00_00_77;
  localparam logic [47:0] MX = 48'h02_99_99_99_99_99;

  initial begin
    int init_cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(reg_cmd[3] == 1'b1, "R1 busy during clear", 64'(reg_cmd[3]), 64'd1);
    init_cyc = 1;
    while (reg_cmd[3]) begin @(negedge clk); init_cyc++; end
    check(init_cyc <= DEPTH + 2, "R1 clear length", 64'(init_cyc), 64'(DEPTH));
    check(reg_cmd == 32'd0, "R1 command after clear", 64'(reg_cmd), 64'd0);

    find("R1 R4 empty table find", MA, 32'd0);
    op("R4 load MA", 3'd2, MA, ent(4'd7, 6'b000010), ent(4'd7, 6'b000010));
    find("R4 find MA", MA, ent(4'd7, 6'b000010));
    op("R4 reload MA", 3'd2, MA, ent(4'd7, 6'b000100), ent(4'd7, 6'b000100));
    find("R4 overwrite in place", MA, ent(4'd7, 6'b000100));
    op("R4 load MB", 3'd2, MB, ent(4'd5, 6'b000010), ent(4'd5, 6'b000010));
    op("R4 load MC", 3'd2, MC, ent(4'd6, 6'b000010), ent(4'd6, 6'b000010));
    op("R4 load MS", 3'd2, MS, ent(4'hF, 6'b000010), ent(4'hF, 6'b000010));

    // R6 walk: slot order MA, MB, MC, MS
    issue("R6 next from zero", 3'd6, 48'd0, 32'd0, 4'd0, ent(4'd7, 6'b000100), MA, 1'b0);
    wait_idle();
    check(reg_addr[31:24] == 8'h02 && reg_cmd[23:16] == 8'h55, "R3 byte placement",
          64'({reg_addr[31:24], reg_cmd[23:16]}), 64'h0255);
    issue("R6 next after MA", 3'd6, MA, ent(4'd7, 6'b000100), 4'd0, ent(4'd5, 6'b000010), MB, 1'b0);
    wait_idle();
    issue("R6 next after MB", 3'd6, MB, ent(4'd5, 6'b000010), 4'd0, ent(4'd6, 6'b000010), MC, 1'b0);
    wait_idle();
    issue("R6 next after MC", 3'd6, MC, ent(4'd6, 6'b000010), 4'd0, ent(4'hF, 6'b000010), MS, 1'b0);
    wait_idle();
    issue("R6 next at end", 3'd6, MS, ent(4'hF, 6'b000010), 4'd0, 32'd0, MS, 1'b0);
    wait_idle();

    lookup("R11 lookup MB", MB, 1'b1, 6'b000010);
    lookup("R11 lookup absent", MX, 1'b0, 6'd0);

    age_pulse(1'b1);
    find("R10 MB aged", MB, ent(4'd4, 6'b000010));
    find("R10 static kept", MS, ent(4'hF, 6'b000010));
    age_pulse(1'b0);
    find("R10 aging disabled", MB, ent(4'd4, 6'b000010));

    issue("R9 flush port 1", 3'd5, MX, 32'd0, 4'd1, 32'd0, MX, 1'b0);
    wait_idle();
    find("R9 MB removed", MB, 32'd0);
    find("R9 other port kept", MA, ent(4'd6, 6'b000100));
    find("R9 multicast kept", MC, ent(4'd5, 6'b000010));
    find("R9 static kept", MS, ent(4'hF, 6'b000010));

    op("R5 purge MA", 3'd3, MA, 32'd0, 32'd0);
    find("R5 MA gone", MA, 32'd0);

    for (int i = 0; i < 6; i++) begin
      op("R7 fill", 3'd2, {40'h02_55_00_00_00, 8'(i)}, ent(4'd3, 6'b000001), ent(4'd3, 6'b000001));
    end
    issue("R7 load into full table", 3'd2, MX, ent(4'd3, 6'b000001), 4'd0,
          ent(4'd3, 6'b000001), MX, 1'b1);
    wait_idle();
    find("R7 full flag cleared, MX absent", MX, 32'd0);

    op("R8 flush non-static", 3'd4, MX, 32'd0, 32'd0);
    find("R8 static survives", MS, ent(4'hF, 6'b000010));
    find("R8 dynamic gone", {40'h02_55_00_00_00, 8'd0}, 32'd0);
    find("R8 MC gone", MC, 32'd0);
    op("R8 flush all", 3'd1, MX, 32'd0, 32'd0);
    find("R8 static gone", MS, 32'd0);

    // R2: writes during a running command are ignored
    issue("R2 find while host writes", 3'd7, MS, 32'd0, 4'd0, 32'd0, MS, 1'b0);
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd0, {16'h1234, 4'h0, 4'h0, 4'h0, 1'b1, 3'd2});
    wait_idle();
    check(reg_cmd[2:0] == 3'd7, "R2 function kept", 64'(reg_cmd[2:0]), 64'd7);
    find("R2 ignored load left table empty", 48'h1234_5678_1234, 32'd0);
    op("R2 no-op", 3'd0, MS, ent(4'd3, 6'b000001), ent(4'd3, 6'b000001));

    repeat (DEPTH + 6) @(negedge clk);
    check(cq.size() == 0 && lq.size() == 0, "R2 R11 all results seen",
          64'(cq.size() + lq.size()), 64'd0);
    finish_run();
  end

endmodule